// File: doc/BRIEF.md
# Audio Interface Interrupt Status, Clear and Enable Unit

This block keeps the interrupt state of a digital audio interface. Single-cycle event pulses from the receiver and transmitter set sticky status bits that stay set until software clears them. Four conditions are levels: receive FIFO full, transmit FIFO empty, Q-channel register full and U-channel register full. These are passed straight through from their sources, and software cannot clear them.

Software reaches the block through a simple register port. One address returns the status word on a read. A write to that same address clears every sticky bit written with a 1. A second address holds a per-bit enable mask. The single interrupt output is raised whenever an enabled status bit is set. When an event and a clear hit the same bit in the same cycle, the event wins.

Top module: `aud_irq_ctrl`

## Requirements
- R1: After a synchronous reset, the status word, the enable word and `irq_o` are all zero while the level inputs are low.
- R2: A one-cycle pulse on a sticky position of `evt_pulse` sets that status bit from the next clock edge, and the bit stays set after the pulse ends. The sticky positions are bits 2 to 7, bit 9 and bits 14 to 20.
- R3: A write to the status address (4) clears, from the next edge, each sticky bit whose write-data bit is 1. Sticky bits written with 0 keep their value.
- R4: The level positions are bit 0 (receive full), bit 1 (transmit empty), bit 8 (Q full) and bit 10 (U full). These status bits equal `lvl_src` in the same cycle, and a clear write to them has no effect.
- R5: When an event pulse and a clear write hit the same sticky bit in the same cycle, the bit is set after that edge.
- R6: Positions 11 to 13 and 21 to 31 always read as zero in both the status word and the enable word, whatever is driven or written there.
- R7: The enable word is written and read back at address 3. Writing it leaves the status word unchanged.
- R8: `irq_o` is 1 exactly when some status bit and the matching enable bit are both 1.
- R9: A read of any other address returns zero, and a write to any other address changes neither the status word nor the enable word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | 32 | Event pulses; only sticky positions are used |
| lvl_src | input | 32 | Level conditions; only level positions are used |
| reg_addr | input | 4 | Register word address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Sticky bits are driven with two patterns: a sparse pair of pulses, and an all-ones pulse. The sparse pair shows that bits are set independently. The all-ones pulse exposes any wrong or extra sticky position. Clear writes are tried with a single bit and with all ones, which separates partial from global clearing. The same all-ones clear is then applied while every level input is high, to show that level bits ignore it. A collision of an event with a clear tells the event-wins rule apart from clear-wins. Enable masks are switched between all ones and a single bit while sticky and level sources take turns, which shows that the interrupt follows the masked OR and not the raw status.

// File: rtl/aud_irq_pkg.sv
package aud_irq_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;

    // Sticky positions: 2..7, 9, 14..20
    localparam logic [DATA_W-1:0] STICKY_MASK = 32'h001F_C2FC;
    // Level positions: 0, 1, 8, 10
    localparam logic [DATA_W-1:0] LEVEL_MASK  = 32'h0000_0503;
    localparam logic [DATA_W-1:0] VALID_MASK  = STICKY_MASK | LEVEL_MASK;

    localparam logic [ADDR_W-1:0] ADDR_STATUS = 4'h4;
    localparam logic [ADDR_W-1:0] ADDR_ENABLE = 4'h3;

    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_ENABLE = 2'd2
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        if (a == ADDR_STATUS)      return SEL_STATUS;
        else if (a == ADDR_ENABLE) return SEL_ENABLE;
        else                       return SEL_NONE;
    endfunction

endpackage

// File: rtl/aud_irq_sticky.sv
module aud_irq_sticky (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    logic q_r;

    always_ff @(posedge clk) begin
        if (rst)        q_r <= 1'b0;
        else if (set_i) q_r <= 1'b1;   // event has priority over clear
        else if (clr_i) q_r <= 1'b0;
    end

    assign q_o = q_r;

    // R5: event in the same cycle as a clear leaves the bit set
    a_r5_event_wins: assert property (@(posedge clk) disable iff (rst)
        set_i |=> q_o);
    // R2: a set bit holds without a clear
    a_r2_sticky_hold: assert property (@(posedge clk) disable iff (rst)
        (q_o && !clr_i) |=> q_o);
    // R3: a clear without an event drops the bit
    a_r3_clear_drops: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> !q_o);
endmodule

// File: rtl/aud_irq_cfg.sv
module aud_irq_cfg
    import aud_irq_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_wr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] en_q,
    output logic [DW-1:0] clr_vec,
    output reg_sel_e      sel
);
    logic [DW-1:0] en_r;

    assign sel = decode_addr(reg_addr);

    always_ff @(posedge clk) begin
        if (rst)
            en_r <= '0;
        else if (reg_wr && sel == SEL_ENABLE)
            en_r <= reg_wdata & VALID_MASK;
    end

    always_comb begin
        clr_vec = '0;
        if (reg_wr && sel == SEL_STATUS)
            clr_vec = reg_wdata & STICKY_MASK;
    end

    assign en_q = en_r;

    // R7: enable word changes only on a write to its address
    a_r7_enable_stable: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && reg_addr == ADDR_ENABLE) |=> $stable(en_q));
endmodule

// File: rtl/aud_irq_ctrl.sv
module aud_irq_ctrl
    import aud_irq_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] evt_pulse,
    input  logic [DW-1:0] lvl_src,
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_wr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq_o
);
    logic [DW-1:0] en_q;
    logic [DW-1:0] clr_vec;
    logic [DW-1:0] sticky_q;
    logic [DW-1:0] status;
    reg_sel_e      sel;

    aud_irq_cfg #(.AW(AW), .DW(DW)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .en_q      (en_q),
        .clr_vec   (clr_vec),
        .sel       (sel)
    );

    for (genvar i = 0; i < DW; i++) begin : g_bit
        if (STICKY_MASK[i]) begin : g_sticky
            aud_irq_sticky u_bit (
                .clk   (clk),
                .rst   (rst),
                .set_i (evt_pulse[i]),
                .clr_i (clr_vec[i]),
                .q_o   (sticky_q[i])
            );
        end else begin : g_none
            assign sticky_q[i] = 1'b0;
        end
    end

    logic unused_in;
    assign unused_in = ^{evt_pulse & ~STICKY_MASK, clr_vec & ~STICKY_MASK};

    assign status = sticky_q | (lvl_src & LEVEL_MASK);

    always_comb begin
        unique case (sel)
            SEL_STATUS: reg_rdata = status;
            SEL_ENABLE: reg_rdata = en_q;
            default:    reg_rdata = '0;
        endcase
    end

    assign irq_o = |(status & en_q);

    // R8: with every enable bit low no interrupt is raised
    a_r8_irq_masked: assert property (@(posedge clk) disable iff (rst)
        (en_q == '0) |-> !irq_o);
endmodule

// File: tb/aud_irq_ctrl_tb.sv
module aud_irq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] evt_pulse = '0;
    logic [31:0] lvl_src = '0;
    logic [3:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    localparam logic [3:0] A_STAT = 4'h4;
    localparam logic [3:0] A_EN   = 4'h3;
    localparam logic [31:0] STICKY = 32'h001F_C2FC;
    localparam logic [31:0] LEVEL  = 32'h0000_0503;

    always #4 clk = ~clk;

    aud_irq_ctrl u_dut (
        .clk(clk), .rst(rst), .evt_pulse(evt_pulse), .lvl_src(lvl_src),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic pulse(input logic [31:0] v);
        @(negedge clk);
        evt_pulse = v;
        @(negedge clk);
        evt_pulse = '0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(A_STAT, d); check("R1 status", d, 32'h0);
        rd(A_EN, d);   check("R1 enable", d, 32'h0);
        check("R1 irq", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic t_sticky();
        logic [31:0] d;
        pulse(32'h0000_0084);
        repeat (2) @(negedge clk);
        rd(A_STAT, d); check("R2 sparse held", d, 32'h0000_0084);
        pulse(32'hFFFF_FFFF);
        rd(A_STAT, d); check("R2 R6 all sticky", d, STICKY);
    endtask

    task automatic t_clear();
        logic [31:0] d;
        wr(A_STAT, 32'h0000_0004);
        rd(A_STAT, d); check("R3 single clear", d, STICKY & ~32'h4);
        wr(A_STAT, 32'hFFFF_FFFF);
        rd(A_STAT, d); check("R3 clear all", d, 32'h0);
    endtask

    task automatic t_level();
        logic [31:0] d;
        @(negedge clk); lvl_src = 32'hFFFF_FFFF;
        rd(A_STAT, d); check("R4 R6 level follow", d, LEVEL);
        wr(A_STAT, 32'hFFFF_FFFF);
        rd(A_STAT, d); check("R4 clear ignored", d, LEVEL);
        @(negedge clk); lvl_src = '0;
        rd(A_STAT, d); check("R4 level drop", d, 32'h0);
    endtask

    task automatic t_race();
        logic [31:0] d;
        @(negedge clk);
        evt_pulse = 32'h0000_4000;
        reg_addr = A_STAT; reg_wdata = 32'h0000_4000; reg_wr = 1'b1;
        @(negedge clk);
        evt_pulse = '0; reg_wr = 1'b0; reg_wdata = '0;
        rd(A_STAT, d); check("R5 event beats clear", d, 32'h0000_4000);
        wr(A_STAT, 32'h0000_4000);
        rd(A_STAT, d); check("R5 later clear", d, 32'h0);
    endtask

    task automatic t_enable();
        logic [31:0] d;
        wr(A_EN, 32'hFFFF_FFFF);
        rd(A_EN, d);   check("R6 R7 enable readback", d, STICKY | LEVEL);
        rd(A_STAT, d); check("R7 status untouched", d, 32'h0);
        check("R8 no status no irq", {31'b0, irq_o}, 32'h0);
        pulse(32'h0000_0200);
        #1 check("R8 irq on sticky", {31'b0, irq_o}, 32'h1);
        wr(A_EN, 32'h0000_0001);
        #1 check("R8 masked", {31'b0, irq_o}, 32'h0);
        @(negedge clk); lvl_src = 32'h0000_0001;
        #1 check("R8 irq on level", {31'b0, irq_o}, 32'h1);
        @(negedge clk); lvl_src = '0;
        #1 check("R8 level gone", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic t_other();
        logic [31:0] d;
        wr(4'h7, 32'hFFFF_FFFF);
        rd(4'h7, d);   check("R9 other read", d, 32'h0);
        rd(A_STAT, d); check("R9 status kept", d, 32'h0000_0200);
        rd(A_EN, d);   check("R9 enable kept", d, 32'h0000_0001);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_sticky();
        t_clear();
        t_level();
        t_race();
        t_enable();
        t_other();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; failures++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule